// File: doc/BRIEF.md
# Software-refilled translation lookaside buffer

This block keeps a small, fully associative set of virtual-to-physical page translations. A lookup presents a virtual address and an access kind (load, store or instruction fetch). In the same cycle the block returns either a translated physical address with a hit flag, a miss exception, or a protection-fault exception. The page offset passes through unchanged, and the stored physical page number takes the place of the virtual page number. The block never walks a page table. A miss is reported to software, which fetches the mapping and installs it.

Privileged software owns the contents through a management port. It can write a complete entry at any index, drop a single entry by writing it with the valid bit low, or drop every entry at once. It can read back the status of one entry, and it can clear every reference bit in one operation. Hardware keeps two bits per entry up to date. The reference bit records use and lets software build an approximate least-recently-used victim choice. The dirty bit records writes, so software knows which pages must be written back before they are replaced.

Top module: `sw_xlat_buffer`

## Requirements
- R1: After reset every entry reads back with valid, dirty and reference bits at 0 and rights code 0. Every lookup misses until software writes an entry.
- R2: On a hit, `lk_paddr` is the stored physical page number concatenated with the low OFF_W = log2(PAGE_BYTES) bits of `lk_vaddr`. `lk_hit` is high in the same cycle as the request.
- R3: When no valid entry holds the requested virtual page number, `lk_miss` is 1, while `lk_hit`, `lk_fault` and `lk_paddr` are 0. No entry state changes.
- R4: Rights codes are 0 read-only (load only), 1 read/write (load or store), 2 execute (fetch only) and 3 no access. Access kinds are 0 load, 1 store, 2 fetch and 3 reserved, and the reserved kind is never allowed. If a matching entry forbids the kind, `lk_fault` is 1 and `lk_hit` and `lk_paddr` are 0.
- R5: Every hit sets the reference bit of the matching entry at the next clock edge.
- R6: A hit whose kind is store also sets the entry's dirty bit at the next edge. Loads and fetches leave the dirty bit alone.
- R7: A fault or a miss changes no reference or dirty bit.
- R8: A management write replaces the whole entry (page numbers, rights, valid, dirty, reference) at one edge. A lookup in the same cycle sees the old contents, and the written values win over that lookup's bit updates.
- R9: Writing an entry with valid 0 invalidates that entry. The invalidate-all strobe clears every valid bit at the next edge, except at an index written in the same cycle.
- R10: The clear-reference strobe zeroes every reference bit at the next edge. An entry hit in the same cycle ends with its reference bit set.
- R11: When more than one valid entry matches, `lk_multi` is 1 and the lowest-index match supplies the rights and the physical page number.
- R12: `mg_rd_valid`, `mg_rd_dirty`, `mg_rd_ref` and `mg_rd_rights` show the current state of the entry at `mg_idx` without delay.
- R13: While `lk_valid` is 0, `lk_hit`, `lk_miss`, `lk_fault` and `lk_multi` are 0, and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | Miss exception |
| lk_fault | output | 1 | Protection-fault exception |
| lk_multi | output | 1 | More than one valid entry matched |
| lk_paddr | output | PA_W | Translated physical address (0 unless hit) |
| mg_wr_en | input | 1 | Write a whole entry at mg_idx |
| mg_idx | input | IDX_W | Entry index for write and readback |
| mg_wr_vpn | input | VA_W-OFF_W | Virtual page number to store |
| mg_wr_ppn | input | PA_W-OFF_W | Physical page number to store |
| mg_wr_rights | input | 2 | Rights code to store |
| mg_wr_valid | input | 1 | Valid bit to store |
| mg_wr_dirty | input | 1 | Dirty bit to store |
| mg_wr_ref | input | 1 | Reference bit to store |
| mg_inval_all | input | 1 | Clear all valid bits |
| mg_clr_ref | input | 1 | Clear all reference bits |
| mg_rd_valid | output | 1 | Valid bit of entry mg_idx |
| mg_rd_dirty | output | 1 | Dirty bit of entry mg_idx |
| mg_rd_ref | output | 1 | Reference bit of entry mg_idx |
| mg_rd_rights | output | 2 | Rights code of entry mg_idx |

## Verification
The assertions check on every cycle that the three lookup outcomes are mutually exclusive and present only with a request. They also check that the page offset survives a hit, that a hit sets the reference bit and a store hit sets the dirty bit unless a write replaces the entry, and that the two bulk strobes clear their bits. Some behaviour can only be shown by the bench's scenarios, which compare against a reference model. That covers the full matrix of rights against access kinds across every entry, the lowest-index choice when entries duplicate, old contents seen by a lookup that shares a cycle with a write, and the precedence between bulk clears, writes and same-cycle hits.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        RGT_RO   = 2'd0,
        RGT_RW   = 2'd1,
        RGT_EX   = 2'd2,
        RGT_NONE = 2'd3
    } rights_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } kind_e;

endpackage

// File: rtl/xlat_perm.sv
module xlat_perm (
    input  xlat_pkg::rights_e rights_i,
    input  xlat_pkg::kind_e   kind_i,
    output logic              allow_o
);
    import xlat_pkg::*;

    always_comb begin
        unique case (rights_i)
            RGT_RO:   allow_o = (kind_i == ACC_LOAD);
            RGT_RW:   allow_o = (kind_i == ACC_LOAD) || (kind_i == ACC_STORE);
            RGT_EX:   allow_o = (kind_i == ACC_FETCH);
            default:  allow_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 22,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_i,
    input  logic [VPN_W-1:0]              look_vpn_i,
    output logic                          any_o,
    output logic                          multi_o,
    output logic [IDX_W-1:0]              idx_o
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = valid_i[g] && (vpn_i[g] == look_vpn_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o   = |eq;
    assign multi_o = ($countones(eq) > 1);

endmodule

// File: rtl/xlat_store.sv
module xlat_store #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 22,
    parameter int PPN_W   = 22,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [IDX_W-1:0]              wr_idx_i,
    input  logic [VPN_W-1:0]              wr_vpn_i,
    input  logic [PPN_W-1:0]              wr_ppn_i,
    input  logic [1:0]                    wr_rights_i,
    input  logic                          wr_valid_i,
    input  logic                          wr_dirty_i,
    input  logic                          wr_ref_i,
    input  logic                          inval_all_i,
    input  logic                          clr_ref_i,
    input  logic                          touch_en_i,
    input  logic [IDX_W-1:0]              touch_idx_i,
    input  logic                          touch_dirty_i,
    output logic [ENTRIES-1:0]            valid_o,
    output logic [ENTRIES-1:0]            dirty_o,
    output logic [ENTRIES-1:0]            ref_o,
    output logic [ENTRIES-1:0][1:0]       rights_o,
    output logic [ENTRIES-1:0][VPN_W-1:0] vpn_o,
    output logic [ENTRIES-1:0][PPN_W-1:0] ppn_o
);
    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0]            dirty;
        logic [ENTRIES-1:0]            refd;
        logic [ENTRIES-1:0][1:0]       rights;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
    } store_t;

    store_t st_d, st_q;

    logic wr_ok, touch_ok;
    assign wr_ok    = wr_en_i && (int'(wr_idx_i) < ENTRIES);
    assign touch_ok = touch_en_i && (int'(touch_idx_i) < ENTRIES);

    always_comb begin
        st_d = st_q;
        if (clr_ref_i)   st_d.refd  = '0;
        if (inval_all_i) st_d.valid = '0;
        if (touch_ok) begin
            st_d.refd[touch_idx_i] = 1'b1;
            if (touch_dirty_i) st_d.dirty[touch_idx_i] = 1'b1;
        end
        if (wr_ok) begin
            st_d.valid[wr_idx_i]  = wr_valid_i;
            st_d.dirty[wr_idx_i]  = wr_dirty_i;
            st_d.refd[wr_idx_i]   = wr_ref_i;
            st_d.rights[wr_idx_i] = wr_rights_i;
            st_d.vpn[wr_idx_i]    = wr_vpn_i;
            st_d.ppn[wr_idx_i]    = wr_ppn_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o  = st_q.valid;
    assign dirty_o  = st_q.dirty;
    assign ref_o    = st_q.refd;
    assign rights_o = st_q.rights;
    assign vpn_o    = st_q.vpn;
    assign ppn_o    = st_q.ppn;

    // R5
    ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_ok && !(wr_en_i && wr_idx_i == touch_idx_i)) |=> st_q.refd[$past(touch_idx_i)]);

    // R6
    dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_ok && touch_dirty_i && !(wr_en_i && wr_idx_i == touch_idx_i))
            |=> st_q.dirty[$past(touch_idx_i)]);

    // R9
    inval_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_all_i && !wr_en_i) |=> (st_q.valid == '0));

    // R10
    clr_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ref_i && !touch_en_i && !wr_en_i) |=> (st_q.refd == '0));

endmodule

// File: rtl/sw_xlat_buffer.sv
module sw_xlat_buffer #(
    parameter int ENTRIES    = 16,
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_BYTES = 1024,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int VPN_W     = VA_W - OFF_W,
    localparam int PPN_W     = PA_W - OFF_W,
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_kind,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic             lk_multi,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             mg_wr_en,
    input  logic [IDX_W-1:0] mg_idx,
    input  logic [VPN_W-1:0] mg_wr_vpn,
    input  logic [PPN_W-1:0] mg_wr_ppn,
    input  logic [1:0]       mg_wr_rights,
    input  logic             mg_wr_valid,
    input  logic             mg_wr_dirty,
    input  logic             mg_wr_ref,
    input  logic             mg_inval_all,
    input  logic             mg_clr_ref,
    output logic             mg_rd_valid,
    output logic             mg_rd_dirty,
    output logic             mg_rd_ref,
    output logic [1:0]       mg_rd_rights
);
    import xlat_pkg::*;

    logic [ENTRIES-1:0]            e_valid, e_dirty, e_ref;
    logic [ENTRIES-1:0][1:0]       e_rights;
    logic [ENTRIES-1:0][VPN_W-1:0] e_vpn;
    logic [ENTRIES-1:0][PPN_W-1:0] e_ppn;

    logic             m_any, m_multi, allow, hit_w;
    logic [IDX_W-1:0] m_idx;
    logic [VPN_W-1:0] look_vpn;
    logic [OFF_W-1:0] look_off;

    assign look_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign look_off = lk_vaddr[OFF_W-1:0];

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
        .valid_i    (e_valid),
        .vpn_i      (e_vpn),
        .look_vpn_i (look_vpn),
        .any_o      (m_any),
        .multi_o    (m_multi),
        .idx_o      (m_idx)
    );

    xlat_perm u_perm (
        .rights_i (rights_e'(e_rights[m_idx])),
        .kind_i   (kind_e'(lk_kind)),
        .allow_o  (allow)
    );

    assign hit_w = lk_valid && m_any && allow;

    xlat_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (mg_wr_en),
        .wr_idx_i      (mg_idx),
        .wr_vpn_i      (mg_wr_vpn),
        .wr_ppn_i      (mg_wr_ppn),
        .wr_rights_i   (mg_wr_rights),
        .wr_valid_i    (mg_wr_valid),
        .wr_dirty_i    (mg_wr_dirty),
        .wr_ref_i      (mg_wr_ref),
        .inval_all_i   (mg_inval_all),
        .clr_ref_i     (mg_clr_ref),
        .touch_en_i    (hit_w),
        .touch_idx_i   (m_idx),
        .touch_dirty_i (lk_kind == ACC_STORE),
        .valid_o       (e_valid),
        .dirty_o       (e_dirty),
        .ref_o         (e_ref),
        .rights_o      (e_rights),
        .vpn_o         (e_vpn),
        .ppn_o         (e_ppn)
    );

    assign lk_hit   = hit_w;
    assign lk_miss  = lk_valid && !m_any;
    assign lk_fault = lk_valid && m_any && !allow;
    assign lk_multi = lk_valid && m_multi;
    assign lk_paddr = hit_w ? {e_ppn[m_idx], look_off} : '0;

    assign mg_rd_valid  = e_valid[mg_idx];
    assign mg_rd_dirty  = e_dirty[mg_idx];
    assign mg_rd_ref    = e_ref[mg_idx];
    assign mg_rd_rights = e_rights[mg_idx];

    // R3 R4 R13
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot({lk_hit, lk_miss, lk_fault}));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault || lk_multi));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_miss || lk_fault) |-> (lk_paddr == '0));

endmodule

// File: tb/tb_sw_xlat_buffer.sv
module tb_sw_xlat_buffer;
    localparam int N = 8;
    localparam int OFF = 10;

    logic clk = 0, rst_n = 0;
    logic lk_valid = 0;
    logic [31:0] lk_vaddr = 0;
    logic [1:0] lk_kind = 0;
    logic lk_hit, lk_miss, lk_fault, lk_multi;
    logic [31:0] lk_paddr;
    logic mg_wr_en = 0, mg_wr_valid = 0, mg_wr_dirty = 0, mg_wr_ref = 0;
    logic [2:0] mg_idx = 0;
    logic [21:0] mg_wr_vpn = 0, mg_wr_ppn = 0;
    logic [1:0] mg_wr_rights = 0;
    logic mg_inval_all = 0, mg_clr_ref = 0;
    logic mg_rd_valid, mg_rd_dirty, mg_rd_ref;
    logic [1:0] mg_rd_rights;

    always #2 clk = ~clk;

    sw_xlat_buffer #(.ENTRIES(N), .VA_W(32), .PA_W(32), .PAGE_BYTES(1024)) dut (.*);

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [21:0] m_vpn [N];
    logic [21:0] m_ppn [N];
    logic [1:0]  m_rgt [N];
    bit m_val [N], m_dty [N], m_ref [N];

    task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    function automatic bit allowed(logic [1:0] r, logic [1:0] k);
        return (r == 0 && k == 0) || (r == 1 && (k == 0 || k == 1)) || (r == 2 && k == 2);
    endfunction

    task automatic finish_cycle();
        @(posedge clk); #1;
        lk_valid = 0; mg_wr_en = 0; mg_inval_all = 0; mg_clr_ref = 0;
    endtask

    task automatic lookup(logic [31:0] va, logic [1:0] k, string rq);
        int m = -1;
        int cnt = 0;
        bit ok = 0;
        for (int i = 0; i < N; i++)
            if (m_val[i] && m_vpn[i] == va[31:OFF]) begin
                cnt++;
                if (m < 0) m = i;
            end
        @(negedge clk);
        lk_valid = 1; lk_vaddr = va; lk_kind = k;
        #1;
        if (m < 0) begin
            chk(rq, "miss", lk_miss, 1);
            chk(rq, "hit", lk_hit, 0);
            chk(rq, "fault", lk_fault, 0);
            chk(rq, "paddr", lk_paddr, 0);
        end else begin
            ok = allowed(m_rgt[m], k);
            chk(rq, "hit", lk_hit, ok);
            chk(rq, "fault", lk_fault, !ok);
            chk(rq, "miss", lk_miss, 0);
            chk(rq, "paddr", lk_paddr, ok ? {m_ppn[m], va[OFF-1:0]} : 32'h0);
        end
        chk(rq, "multi", lk_multi, cnt > 1);
        finish_cycle();
        if (m >= 0 && ok) begin
            m_ref[m] = 1;
            if (k == 1) m_dty[m] = 1;
        end
    endtask

    task automatic mgwrite(int idx, logic [21:0] vpn, logic [21:0] ppn, logic [1:0] r,
                           bit v, bit d, bit rf);
        @(negedge clk);
        mg_wr_en = 1; mg_idx = 3'(idx); mg_wr_vpn = vpn; mg_wr_ppn = ppn;
        mg_wr_rights = r; mg_wr_valid = v; mg_wr_dirty = d; mg_wr_ref = rf;
        finish_cycle();
        m_vpn[idx] = vpn; m_ppn[idx] = ppn; m_rgt[idx] = r;
        m_val[idx] = v; m_dty[idx] = d; m_ref[idx] = rf;
    endtask

    task automatic rb_all(string rq);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            mg_idx = 3'(i);
            #1;
            chk(rq, $sformatf("valid[%0d]", i), mg_rd_valid, m_val[i]);
            chk(rq, $sformatf("dirty[%0d]", i), mg_rd_dirty, m_dty[i]);
            chk(rq, $sformatf("ref[%0d]", i), mg_rd_ref, m_ref[i]);
            chk(rq, $sformatf("rights[%0d]", i), mg_rd_rights, m_rgt[i]);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vpn[i] = 0; m_ppn[i] = 0; m_rgt[i] = 0;
            m_val[i] = 0; m_dty[i] = 0; m_ref[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 R12: reset state and misses on empty buffer
        rb_all("R1 R12");
        for (int v = 0; v < 4; v++) lookup({22'(v * 7), 10'h0}, 2'(v), "R1");

        // R8: fill every entry
        for (int i = 0; i < N; i++)
            mgwrite(i, 22'(i * 3 + 5), 22'(i + 100), 2'(i % 4), 1, 0, 0);
        rb_all("R8 R12");

        // R13: idle request drives no outcome
        @(negedge clk);
        lk_valid = 0; lk_vaddr = {22'd5, 10'h0}; lk_kind = 1; #1;
        chk("R13", "hit", lk_hit, 0);
        chk("R13", "miss", lk_miss, 0);
        chk("R13", "fault", lk_fault, 0);
        chk("R13", "multi", lk_multi, 0);
        finish_cycle();
        rb_all("R13");

        // R3: unmapped page
        for (int k = 0; k < 4; k++) lookup({22'd1000, 10'h2A}, 2'(k), "R3");
        rb_all("R3");

        // R2 R4: every entry against every access kind and several offsets
        for (int i = 0; i < N; i++)
            for (int k = 0; k < 4; k++) begin
                lookup({22'(i * 3 + 5), 10'h000}, 2'(k), "R2 R4");
                lookup({22'(i * 3 + 5), 10'h3FF}, 2'(k), "R2 R4");
                lookup({22'(i * 3 + 5), 10'(i * 37)}, 2'(k), "R2 R4");
            end
        rb_all("R5 R6 R7");

        // R10: bulk clear of reference bits
        @(negedge clk); mg_clr_ref = 1; finish_cycle();
        for (int i = 0; i < N; i++) m_ref[i] = 0;
        rb_all("R10");
        // R10: clear with a same-cycle load hit on entry 1
        @(negedge clk);
        mg_clr_ref = 1; lk_valid = 1; lk_vaddr = {m_vpn[1], 10'h11}; lk_kind = 0; #1;
        chk("R10", "hit", lk_hit, 1);
        finish_cycle();
        m_ref[1] = 1;
        rb_all("R10");

        // R8: write and lookup of the same entry in one cycle
        @(negedge clk);
        mg_wr_en = 1; mg_idx = 0; mg_wr_vpn = m_vpn[0]; mg_wr_ppn = 22'd200;
        mg_wr_rights = 1; mg_wr_valid = 1; mg_wr_dirty = 0; mg_wr_ref = 0;
        lk_valid = 1; lk_vaddr = {m_vpn[0], 10'h55}; lk_kind = 0; #1;
        chk("R8", "old hit", lk_hit, 1);
        chk("R8", "old paddr", lk_paddr, {22'd100, 10'h55});
        finish_cycle();
        m_ppn[0] = 200; m_rgt[0] = 1; m_ref[0] = 0; m_dty[0] = 0;
        rb_all("R8");
        lookup({m_vpn[0], 10'h77}, 1, "R8");

        // R11: duplicate tag, lowest index wins
        mgwrite(6, m_vpn[1], 22'd300, 2'd2, 1, 0, 0);
        lookup({m_vpn[1], 10'h123}, 1, "R11");
        lookup({m_vpn[1], 10'h0F0}, 2, "R11");
        rb_all("R11");

        // R9: single invalidate, then invalidate-all with a same-cycle write
        mgwrite(3, m_vpn[3], m_ppn[3], m_rgt[3], 0, m_dty[3], m_ref[3]);
        lookup({22'(3 * 3 + 5), 10'h0}, 0, "R9");
        @(negedge clk);
        mg_inval_all = 1; mg_wr_en = 1; mg_idx = 2; mg_wr_vpn = 22'd77; mg_wr_ppn = 22'd400;
        mg_wr_rights = 2; mg_wr_valid = 1; mg_wr_dirty = 1; mg_wr_ref = 1;
        finish_cycle();
        for (int i = 0; i < N; i++) m_val[i] = 0;
        m_vpn[2] = 77; m_ppn[2] = 400; m_rgt[2] = 2; m_val[2] = 1; m_dty[2] = 1; m_ref[2] = 1;
        rb_all("R9");
        lookup({22'd77, 10'h3C}, 2, "R9");
        lookup({22'(4 * 3 + 5), 10'h0}, 0, "R9");
        lookup({m_vpn[1], 10'h0}, 0, "R9");

        summary();
    end

endmodule